// File: doc/BRIEF.md
# Interrupt Redirection Register File

This block holds the redirection table of an interrupt routing controller and makes it reachable through just two bus locations. Software first writes an 8-bit index into the select port. It then reads or writes the data window, which is routed to whichever internal register that index names. The internal registers are a read-only version word, an identification word, an arbitration word, and two 32-bit halves for each 64-bit redirection entry. There is one entry per interrupt input.

Every field of every entry is driven out in parallel to the delivery logic. The delivery logic drives back set and clear strobes for the two status bits that software cannot write: the waiting-for-acknowledge flag and the delivery-in-progress flag. When a software write flips an entry's mask bit, the block raises a one-cycle pulse that carries the pin number.

Bus reads are combinational and have no side effects. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `irq_route_regs`

## Requirements
- R1: A write at offset 0x00 stores bits 7:0 of the data as the select index. A read at offset 0x00 returns that index zero-extended to 32 bits.
- R2: Only offsets 0x00 (select) and 0x10 (window) respond. A read at any other offset returns 0, and a write there changes nothing.
- R3: Index 0x00 reads as (NPINS-1) in bits 23:16 and VERSION in bits 7:0, which is 0x00170011 with the default parameters. Writes to it are ignored.
- R4: A write to index 0x01 loads the 4-bit ID from data bits 27:24. Reads of index 0x01 and of index 0x02 both return the ID in bits 27:24 and zeros elsewhere. Writes to index 0x02 are ignored.
- R5: Entry n is reached at index 0x10+2n. The even index gives bits 31:0 and the odd index gives bits 63:32. The fields are: vector in 7:0, delivery mode in 10:8, destination mode in 11, delivery status in 12, polarity in 13, remote IRR in 14, trigger in 15 (1 = level, 0 = edge), mask in 16, and destination in 63:56.
- R6: Indexes 0x03 to 0x0F, and indexes past the last entry, read as 0xFFFFFFFF. A write to any of them has no effect.
- R7: A window write to an entry half leaves bit 14 (remote IRR) and bit 12 (delivery status) at their prior values, whatever the data holds.
- R8: If an entry's trigger bit is 0 after a write to it, its remote IRR becomes 0. This overrides a set strobe in the same cycle.
- R9: The strobes `rirr_set`/`rirr_clr` and `dstat_set`/`dstat_clr` update the status bits of the matching entry at the next edge. Set wins over clear.
- R10: When a write flips an entry's mask bit, `mask_chg` is high for exactly the following cycle and `mask_pin` gives the entry number. A write that leaves the mask bit unchanged produces no pulse.
- R11: Reset leaves every entry holding 0x0000000000010000 (mask set, all else 0), with the select index at 0 and the ID at 0.
- R12: The field outputs always present the stored table, with entry n in slice n of each flat vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed offset |
| bus_off | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_off` (combinational) |
| rirr_set | input | NPINS | Set remote IRR of entry n |
| rirr_clr | input | NPINS | Clear remote IRR of entry n |
| dstat_set | input | NPINS | Set delivery status of entry n |
| dstat_clr | input | NPINS | Clear delivery status of entry n |
| f_vector | output | 8*NPINS | Vector of each entry |
| f_dmode | output | 3*NPINS | Delivery mode of each entry |
| f_dstmode | output | NPINS | Destination mode of each entry |
| f_dstat | output | NPINS | Delivery status of each entry |
| f_pol | output | NPINS | Polarity of each entry |
| f_rirr | output | NPINS | Remote IRR of each entry |
| f_trig | output | NPINS | Trigger mode of each entry (1 = level) |
| f_mask | output | NPINS | Mask of each entry |
| f_dest | output | 8*NPINS | Destination of each entry |
| mask_chg | output | 1 | One-cycle pulse after a mask bit flips |
| mask_pin | output | $clog2(NPINS) | Entry whose mask flipped |

## Verification
Two functions can hit the same status bit in the same clock cycle: a software window write that turns an entry to edge trigger, and the delivery logic's remote IRR set strobe. The bench provokes this by driving `rirr_set` high in the very cycle of such a write. It judges the outcome by `f_rirr` staying 0 afterwards. It also runs the same collision with a level-trigger write, where the write must preserve the flag and a set must take hold. Set and clear strobes for the same bit are raised together, and set must win.

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int NPINS = 24,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int IW = $clog2(NPINS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_off,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NPINS-1:0]     rirr_set,
  input  logic [NPINS-1:0]     rirr_clr,
  input  logic [NPINS-1:0]     dstat_set,
  input  logic [NPINS-1:0]     dstat_clr,
  output logic [8*NPINS-1:0]   f_vector,
  output logic [3*NPINS-1:0]   f_dmode,
  output logic [NPINS-1:0]     f_dstmode,
  output logic [NPINS-1:0]     f_dstat,
  output logic [NPINS-1:0]     f_pol,
  output logic [NPINS-1:0]     f_rirr,
  output logic [NPINS-1:0]     f_trig,
  output logic [NPINS-1:0]     f_mask,
  output logic [8*NPINS-1:0]   f_dest,
  output logic                 mask_chg,
  output logic [IW-1:0]        mask_pin
);

  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [63:0] ENT_RST = 64'h0000_0000_0001_0000;
  localparam int B_DSTAT = 12;
  localparam int B_RIRR  = 14;
  localparam int B_TRIG  = 15;
  localparam int B_MASK  = 16;

  logic [7:0]  sel;
  logic [3:0]  id;
  logic [63:0] tbl [NPINS];
  logic [63:0] nxt [NPINS];
  logic [NPINS-1:0] hit;

  logic [7:0] sel_rel;
  logic [6:0] eidx;
  logic       ent_ok;
  logic       win_wr;
  logic [63:0] rd_ent;
  logic [31:0] win_rd;
  logic        mchg_d;

  assign sel_rel = sel - 8'h10;
  assign eidx    = sel_rel[7:1];
  assign ent_ok  = (sel >= 8'h10) && (eidx < 7'(NPINS));
  assign win_wr  = bus_wr && (bus_off == OFF_WIN);
  assign rd_ent  = ent_ok ? tbl[eidx[IW-1:0]] : '1;

  always_comb begin
    if (sel == 8'h00)
      win_rd = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};
    else if (sel == 8'h01 || sel == 8'h02)
      win_rd = {4'h0, id, 24'h0};
    else
      win_rd = sel[0] ? rd_ent[63:32] : rd_ent[31:0];
  end

  always_comb begin
    case (bus_off)
      OFF_SEL: bus_rdata = {24'h0, sel};
      OFF_WIN: bus_rdata = win_rd;
      default: bus_rdata = 32'h0;
    endcase
  end

  always_comb begin
    mchg_d = 1'b0;
    for (int n = 0; n < NPINS; n++) begin
      hit[n] = win_wr && ent_ok && (eidx == 7'(n));
      nxt[n] = tbl[n];
      if (hit[n]) begin
        nxt[n] = sel[0] ? {bus_wdata, tbl[n][31:0]} : {tbl[n][63:32], bus_wdata};
        nxt[n][B_RIRR]  = tbl[n][B_RIRR];
        nxt[n][B_DSTAT] = tbl[n][B_DSTAT];
        if (nxt[n][B_MASK] != tbl[n][B_MASK]) mchg_d = 1'b1;
      end
      if (hit[n] && !nxt[n][B_TRIG]) nxt[n][B_RIRR] = 1'b0;
      else if (rirr_set[n])          nxt[n][B_RIRR] = 1'b1;
      else if (rirr_clr[n])          nxt[n][B_RIRR] = 1'b0;
      if (dstat_set[n])      nxt[n][B_DSTAT] = 1'b1;
      else if (dstat_clr[n]) nxt[n][B_DSTAT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel      <= 8'h00;
      id       <= 4'h0;
      mask_chg <= 1'b0;
      mask_pin <= '0;
      for (int n = 0; n < NPINS; n++) tbl[n] <= ENT_RST;
    end else begin
      if (bus_wr && bus_off == OFF_SEL) sel <= bus_wdata[7:0];
      if (win_wr && sel == 8'h01) id <= bus_wdata[27:24];
      mask_chg <= mchg_d;
      mask_pin <= eidx[IW-1:0];
      for (int n = 0; n < NPINS; n++) tbl[n] <= nxt[n];
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_fld
    assign f_vector[8*g +: 8] = tbl[g][7:0];
    assign f_dmode[3*g +: 3]  = tbl[g][10:8];
    assign f_dstmode[g]       = tbl[g][11];
    assign f_dstat[g]         = tbl[g][B_DSTAT];
    assign f_pol[g]           = tbl[g][13];
    assign f_rirr[g]          = tbl[g][B_RIRR];
    assign f_trig[g]          = tbl[g][B_TRIG];
    assign f_mask[g]          = tbl[g][B_MASK];
    assign f_dest[8*g +: 8]   = tbl[g][63:56];

    AST_EDGE_CLEARS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && ent_ok && eidx == 7'(g)) |=> (f_trig[g] || !f_rirr[g])); // R8
    AST_DSTAT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && ent_ok && eidx == 7'(g) && !dstat_set[g] && !dstat_clr[g]) |=> $stable(f_dstat[g])); // R7
    AST_MASK_PULSE_REAL: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_chg && mask_pin == IW'(g)) |-> !$stable(f_mask[g])); // R10
  end

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == OFF_SEL) |=> (sel == $past(bus_wdata[7:0]))); // R1
  AST_ID_ONLY_IDX1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_off == OFF_WIN && sel == 8'h01) |=> $stable(id)); // R4
  AST_OTHER_OFF_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off != OFF_SEL) |=> $stable(sel)); // R2

endmodule

// File: tb/test_irq_route_regs.sv
module test_irq_route_regs;
  localparam int NP = 24;
  localparam int IW = $clog2(NP);

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_off = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [NP-1:0] rirr_set = 0, rirr_clr = 0, dstat_set = 0, dstat_clr = 0;
  logic [8*NP-1:0] f_vector, f_dest;
  logic [3*NP-1:0] f_dmode;
  logic [NP-1:0] f_dstmode, f_dstat, f_pol, f_rirr, f_trig, f_mask;
  logic mask_chg;
  logic [IW-1:0] mask_pin;
  int total = 0, bad = 0;

  irq_route_regs #(.NPINS(NP)) i_irq_route_regs (.*);

  always #10 clk = ~clk;

  // {write, offset, data, expected read}
  localparam int NV = 25;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'h0000_0000, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h0017_0011},        // R3
    {1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h0017_0011},        // R3 write ignored
    {1'b1, 8'h00, 32'h0000_0001, 32'h0},
    {1'b1, 8'h10, 32'hA500_0000, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h0500_0000},        // R4
    {1'b1, 8'h00, 32'h0000_0002, 32'h0},
    {1'b1, 8'h10, 32'h0F00_0000, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h0500_0000},        // R4 arb read, write ignored
    {1'b1, 8'h00, 32'h0000_0012, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h0001_0000},        // R11 entry 1 low
    {1'b1, 8'h10, 32'h0000_F0FF, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h0000_A0FF},        // R7 R5
    {1'b1, 8'h00, 32'h0000_0013, 32'h0},
    {1'b1, 8'h10, 32'h7F00_0000, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h7F00_0000},        // R5 high half
    {1'b1, 8'h00, 32'h0000_0040, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'hFFFF_FFFF},        // R6 past last
    {1'b1, 8'h00, 32'h0000_000F, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'hFFFF_FFFF},        // R6 gap
    {1'b1, 8'h00, 32'h0000_01FF, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'h0000_00FF},        // R1
    {1'b1, 8'h20, 32'h0000_0033, 32'h0},
    {1'b0, 8'h20, 32'h0, 32'h0}                 // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_off = off; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] off, output logic [31:0] d);
    @(negedge clk); bus_wr = 0; bus_off = off; #2 d = bus_rdata;
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [8*NP-1:0] sv_vec;
    logic [NP-1:0] sv_msk;
    #45 rst_n = 1;
    // R11 reset state
    check("R11 mask", 32'(f_mask), 32'(24'hFF_FFFF));
    check("R11 rirr", 32'(f_rirr), 32'h0);
    rd(8'h00, r); check("R11 sel", r, 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][72]) wr(VEC[k][71:64], VEC[k][63:32]);
      else begin
        rd(VEC[k][71:64], r);
        check($sformatf("R1-table step %0d", k), r, VEC[k][31:0]);
      end
    end
    // R12 field outputs of entry 1
    check("R12 vector", 32'(f_vector[15:8]), 32'hFF);
    check("R12 dest", 32'(f_dest[15:8]), 32'h7F);
    check("R12 trig/pol/mask", {29'h0, f_trig[1], f_pol[1], f_mask[1]}, 32'h6);
    rd(8'h00, r); check("R2 sel unchanged", r, 32'hFF);

    // R6 writes to unmapped indexes change nothing
    sv_vec = f_vector; sv_msk = f_mask;
    wr(8'h00, 32'h40); wr(8'h10, 32'h0);
    wr(8'h00, 32'h05); wr(8'h10, 32'h0);
    check("R6 mask", 32'(sv_msk ^ f_mask), 32'h0);
    check("R6 vector", 32'(|(sv_vec ^ f_vector)), 32'h0);

    // R10 mask pulse
    wr(8'h00, 32'h14); wr(8'h10, 32'h0);
    check("R10 pulse", {31'h0, mask_chg}, 32'h1);
    check("R10 pin", 32'(mask_pin), 32'h2);
    @(negedge clk); check("R10 one cycle", {31'h0, mask_chg}, 32'h0);
    wr(8'h10, 32'h0);
    check("R10 no flip no pulse", {31'h0, mask_chg}, 32'h0);

    // R9 R7 R8 remote IRR of entry 3
    wr(8'h00, 32'h16); wr(8'h10, 32'h0000_8030);
    @(negedge clk); rirr_set[3] = 1; @(negedge clk); rirr_set[3] = 0;
    check("R9 set", {31'h0, f_rirr[3]}, 32'h1);
    rd(8'h10, r); check("R5 R9 readback", r, 32'h0000_C030);
    wr(8'h10, 32'h0000_8031);
    rd(8'h10, r); check("R7 rirr kept", r, 32'h0000_C031);
    @(negedge clk); rirr_set[3] = 1; rirr_clr[3] = 1;
    @(negedge clk); rirr_set[3] = 0; rirr_clr[3] = 0;
    check("R9 set wins", {31'h0, f_rirr[3]}, 32'h1);
    @(negedge clk); bus_wr = 1; bus_off = 8'h10; bus_wdata = 32'h0000_4031; rirr_set[3] = 1;
    @(negedge clk); bus_wr = 0; rirr_set[3] = 0;
    check("R8 edge beats set", {31'h0, f_rirr[3]}, 32'h0);
    @(negedge clk); bus_wr = 1; bus_wdata = 32'h0000_8031; rirr_set[3] = 1;
    @(negedge clk); bus_wr = 0; rirr_set[3] = 0;
    check("R9 level write with set", {31'h0, f_rirr[3]}, 32'h1);

    // R7 delivery status of entry 4
    @(negedge clk); dstat_set[4] = 1; @(negedge clk); dstat_set[4] = 0;
    wr(8'h00, 32'h18); wr(8'h10, 32'h0);
    rd(8'h10, r); check("R7 dstat kept", r, 32'h0000_1000);
    @(negedge clk); dstat_clr[4] = 1; @(negedge clk); dstat_clr[4] = 0;
    check("R9 dstat clear", {31'h0, f_dstat[4]}, 32'h0);

    // R11 reset mid-run
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(8'h00, r); check("R11 sel after reset", r, 32'h0);
    check("R11 mask after reset", 32'(f_mask), 32'(24'hFF_FFFF));
    wr(8'h00, 32'h01); rd(8'h10, r); check("R11 id after reset", r, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule